// File: doc/BRIEF.md
# Single-Wire Pulse-Count Dimming Decoder

This block sits beside a constant-current LED sink. It turns short low-going pulses on the sink's enable line into a brightness setting. It has no dedicated dimming pins. The line is sampled through a two-stage synchroniser, and the lengths of its low and high periods are measured in clock cycles. From those lengths the block decides whether a rising edge ends a genuine dimming pulse, a glitch, an ordinary off period, or a shutdown.

The setting is a 3-bit index from 0 to 7, and each index has a fixed percentage of full-scale current. Index 0 is 100 %. Every accepted pulse moves one step dimmer, and the step after the dimmest level returns to full scale. After shutdown, pulses are not decoded until the line has been held high for an initialisation window. If the line stays low for the shutdown time, the block forgets the setting and shuts down. While the line is high and the block is not in shutdown, the drive flag follows the line, so plain PWM on the same line also dims the LEDs.

All thresholds are parameters counted in clock cycles. The defaults assume a 10 MHz clock.

Top module: `pulse_dim_decoder`

## Requirements
- R1: While and directly after synchronous reset, `shutdown` is 1, `drive_on` is 0, `level_idx` is 0 and `pct_code` is 100.
- R2: `pct_code` reports the percentage for `level_idx`. Index 0 through 7 map to 100, 87, 74, 61, 47, 34, 21 and 8.
- R3: A pulse is accepted when the synchronised line rises after a low period of MIN_LOW to MAX_LOW cycles, and the high period before that low lasted at least MIN_HIGH cycles. An accepted pulse increments `level_idx` by one. The new value is visible three clock edges after the input rise.
- R4: An accepted pulse at index 7 sets `level_idx` to 0 (100 %).
- R5: After reset or after shutdown, no pulse is accepted until the line has been high for INIT_HIGH consecutive cycles.
- R6: A low period shorter than MIN_LOW cycles is a glitch. It leaves `level_idx` unchanged.
- R7: A low period longer than MAX_LOW cycles but shorter than SHDN_LOW cycles does not change `level_idx` and does not enter shutdown.
- R8: A low period of SHDN_LOW cycles sets `shutdown`, sets `level_idx` to 0 and requires a new initialisation window.
- R9: `drive_on` equals the synchronised line delayed by one cycle. It is therefore 0 while the line is low and whenever `shutdown` is 1. `shutdown` clears on the first synchronised high cycle.
- R10: A pulse whose preceding high period was shorter than MIN_HIGH cycles is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en_in | input | 1 | Asynchronous enable / serial dimming line |
| level_idx | output | 3 | Current dimming step, 0 = full scale |
| pct_code | output | 7 | Percentage of full-scale current for the step |
| drive_on | output | 1 | Current sink enabled this cycle |
| shutdown | output | 1 | Block is in shutdown |

## Verification
The bench concentrates on the edges of the low-time window. A 2-cycle glitch must not step the level, and neither must a 30-cycle gap. A decoder that only looks at edges would step on both, and one that lets a long gap through would dim at every PWM off period. It also sends pulses inside the initialisation window and pulses that follow a high period that is too short. A design that skips either qualification takes dimming steps that the sink never asked for. The wrap from the dimmest level back to full scale and the forced return to index 0 after a long low are checked directly. A counter without the wrap, or one that survives shutdown, would leave the LEDs at the wrong brightness.

// File: rtl/pdd_pkg.sv
package pdd_pkg;
  localparam int LEVELS = 8;
  localparam int LVL_W  = $clog2(LEVELS);
  localparam int PCT_W  = 7;

  // percentage of full scale for a dimming step: 13 % per step,
  // one extra percent dropped from the upper half onwards
  function automatic logic [PCT_W-1:0] pct_of(input logic [LVL_W-1:0] idx);
    int v;
    v = 100 - 13 * int'(idx) - ((int'(idx) >= LEVELS / 2) ? 1 : 0);
    return PCT_W'(v);
  endfunction

  // next dimmer step with wrap to full scale
  function automatic logic [LVL_W-1:0] step_next(input logic [LVL_W-1:0] idx);
    return (int'(idx) == LEVELS - 1) ? '0 : idx + 1'b1;
  endfunction

  // width of a saturating counter that must reach lim
  function automatic int cnt_width(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    m = (m > c) ? m : c;
    return $clog2(m + 2);
  endfunction
endpackage

// File: rtl/pdd_sync.sv
module pdd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pdd_width_meter.sv
module pdd_width_meter #(
  parameter int MIN_LOW   = 5,
  parameter int MAX_LOW   = 200,
  parameter int MIN_HIGH  = 5,
  parameter int INIT_HIGH = 10000,
  parameter int SHDN_LOW  = 10000,
  localparam int CW = pdd_pkg::cnt_width(MAX_LOW, INIT_HIGH, SHDN_LOW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s,
  output logic          rise_evt,
  output logic [CW-1:0] low_len,
  output logic          pulse_ok,
  output logic          long_low,
  output logic          init_reached
);
  localparam logic [CW-1:0] SAT = '1;

  logic [CW-1:0] low_cnt;
  logic [CW-1:0] high_cnt;
  logic          hi_ok;
  logic          fall_evt;

  assign rise_evt     = s && (low_cnt != '0);
  assign fall_evt     = !s && (high_cnt != '0);
  assign low_len      = low_cnt;
  assign pulse_ok     = rise_evt && hi_ok &&
                        (low_cnt >= CW'(MIN_LOW)) && (low_cnt <= CW'(MAX_LOW));
  assign long_low     = !s && (low_cnt == CW'(SHDN_LOW - 1));
  assign init_reached = s && (high_cnt == CW'(INIT_HIGH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt  <= '0;
      high_cnt <= '0;
      hi_ok    <= 1'b0;
    end else if (s) begin
      low_cnt <= '0;
      if (high_cnt != SAT) high_cnt <= high_cnt + 1'b1;
    end else begin
      high_cnt <= '0;
      if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
      if (fall_evt) hi_ok <= (high_cnt >= CW'(MIN_HIGH));
    end
  end
endmodule

// File: rtl/pdd_level_stepper.sv
module pdd_level_stepper
  import pdd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             s,
  input  logic             pulse_ok,
  input  logic             long_low,
  input  logic             init_reached,
  output logic [LVL_W-1:0] level,
  output logic             armed,
  output logic             sd,
  output logic             drive_on
);
  always_ff @(posedge clk) begin
    if (rst) begin
      level    <= '0;
      armed    <= 1'b0;
      sd       <= 1'b1;
      drive_on <= 1'b0;
    end else begin
      drive_on <= s;
      if (long_low) begin
        sd    <= 1'b1;
        armed <= 1'b0;
        level <= '0;
      end else if (s) begin
        sd <= 1'b0;
        if (init_reached) armed <= 1'b1;
        if (pulse_ok && armed) level <= step_next(level);
      end
    end
  end
endmodule

// File: rtl/pulse_dim_decoder.sv
module pulse_dim_decoder #(
  parameter int MIN_LOW   = 5,
  parameter int MAX_LOW   = 200,
  parameter int MIN_HIGH  = 5,
  parameter int INIT_HIGH = 10000,
  parameter int SHDN_LOW  = 10000,
  parameter int SYNC_STG  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_in,
  output logic [2:0] level_idx,
  output logic [6:0] pct_code,
  output logic       drive_on,
  output logic       shutdown
);
  import pdd_pkg::*;
  localparam int CW = cnt_width(MAX_LOW, INIT_HIGH, SHDN_LOW);

  logic          s_en;
  logic          rise_evt;
  logic [CW-1:0] low_len;
  logic          pulse_ok;
  logic          long_low;
  logic          init_reached;
  logic          armed;

  pdd_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d(en_in), .q(s_en)
  );

  pdd_width_meter #(
    .MIN_LOW(MIN_LOW), .MAX_LOW(MAX_LOW), .MIN_HIGH(MIN_HIGH),
    .INIT_HIGH(INIT_HIGH), .SHDN_LOW(SHDN_LOW)
  ) u_meter (
    .clk(clk), .rst(rst), .s(s_en),
    .rise_evt(rise_evt), .low_len(low_len), .pulse_ok(pulse_ok),
    .long_low(long_low), .init_reached(init_reached)
  );

  pdd_level_stepper u_step (
    .clk(clk), .rst(rst), .s(s_en),
    .pulse_ok(pulse_ok), .long_low(long_low), .init_reached(init_reached),
    .level(level_idx), .armed(armed), .sd(shutdown), .drive_on(drive_on)
  );

  assign pct_code = pct_of(level_idx);
endmodule

// File: rtl/pdd_checker.sv
module pdd_checker #(
  parameter int MIN_LOW = 5,
  parameter int MAX_LOW = 200,
  parameter int CW      = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          rise_evt,
  input logic [CW-1:0] low_len,
  input logic          pulse_ok,
  input logic          armed,
  input logic [2:0]    level_idx,
  input logic          shutdown,
  input logic          drive_on
);
  import pdd_pkg::*;

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (pulse_ok && armed) |=> (level_idx == step_next($past(level_idx))));

  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (pulse_ok && armed && level_idx == 3'd7) |=> (level_idx == 3'd0));

  p_hold_unarmed_r5: assert property (@(posedge clk) disable iff (rst)
    (!armed) |=> ($stable(level_idx) || level_idx == 3'd0));

  p_glitch_r6: assert property (@(posedge clk) disable iff (rst)
    (rise_evt && int'(low_len) < MIN_LOW) |=> $stable(level_idx));

  p_gap_r7: assert property (@(posedge clk) disable iff (rst)
    (rise_evt && int'(low_len) > MAX_LOW) |=> ($stable(level_idx) && !shutdown));

  p_sd_reset_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(shutdown) |-> (level_idx == 3'd0 && !armed));

  p_drive_gate_r9: assert property (@(posedge clk) disable iff (rst)
    drive_on |-> !shutdown);
endmodule

bind pulse_dim_decoder pdd_checker #(
  .MIN_LOW(MIN_LOW), .MAX_LOW(MAX_LOW), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .rise_evt(rise_evt), .low_len(low_len),
  .pulse_ok(pulse_ok), .armed(armed), .level_idx(level_idx),
  .shutdown(shutdown), .drive_on(drive_on)
);

// File: tb/sim_pulse_dim_decoder.sv
module sim_pulse_dim_decoder;
  localparam int P_MIN_LOW = 4;
  localparam int P_MAX_LOW = 20;
  localparam int P_MIN_HI  = 4;
  localparam int P_INIT    = 40;
  localparam int P_SHDN    = 60;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [2:0] level_idx;
  logic [6:0] pct_code;
  logic       drive_on;
  logic       shutdown;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int pct_tab [8] = '{100, 87, 74, 61, 47, 34, 21, 8};

  always #4 clk = ~clk;

  pulse_dim_decoder #(
    .MIN_LOW(P_MIN_LOW), .MAX_LOW(P_MAX_LOW), .MIN_HIGH(P_MIN_HI),
    .INIT_HIGH(P_INIT), .SHDN_LOW(P_SHDN)
  ) u0 (
    .clk(clk), .rst(rst), .en_in(en), .level_idx(level_idx),
    .pct_code(pct_code), .drive_on(drive_on), .shutdown(shutdown)
  );

  // behavioural reference: run lengths of the delayed line
  int m_q1, m_q2, m_low, m_high, m_hiok, m_armed, m_sd, m_lvl, m_drv;
  initial begin
    m_q1 = 0; m_q2 = 0; m_low = 0; m_high = 0; m_hiok = 0;
    m_armed = 0; m_sd = 1; m_lvl = 0; m_drv = 0;
  end

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s t=%0t got=%0d exp=%0d", tag, $time, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_q1 = 0; m_q2 = 0; m_low = 0; m_high = 0; m_hiok = 0;
      m_armed = 0; m_sd = 1; m_lvl = 0; m_drv = 0;
    end else begin
      if (m_q2 == 0) begin
        if (m_high > 0) m_hiok = (m_high >= P_MIN_HI) ? 1 : 0;
        m_high = 0;
        m_low  = m_low + 1;
        if (m_low == P_SHDN) begin m_sd = 1; m_lvl = 0; m_armed = 0; end
        m_drv = 0;
      end else begin
        if (m_low > 0 && m_armed == 1 && m_hiok == 1 &&
            m_low >= P_MIN_LOW && m_low <= P_MAX_LOW)
          m_lvl = (m_lvl + 1) % 8;
        m_low  = 0;
        m_high = m_high + 1;
        if (m_high == P_INIT) m_armed = 1;
        m_sd  = 0;
        m_drv = 1;
      end
      m_q2 = m_q1;
      m_q1 = int'(en);
    end
    #2;
    if (!rst && !done) begin
      chk("R3 model level",    int'(level_idx), m_lvl);
      chk("R2 model pct",      int'(pct_code),  pct_tab[m_lvl]);
      chk("R8 model shutdown", int'(shutdown),  m_sd);
      chk("R9 model drive_on", int'(drive_on),  m_drv);
    end
  end

  task automatic hold(input logic v, input int n);
    en = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int lo, input int hi);
    hold(1'b0, lo);
    hold(1'b1, hi);
  endtask

  task automatic expect_lvl(input string tag, input int idx);
    chk(tag, int'(level_idx), idx);
    chk(tag, int'(pct_code), pct_tab[idx]);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 shutdown", int'(shutdown), 1);
    chk("R1 drive_on", int'(drive_on), 0);
    expect_lvl("R1 level", 0);

    // R9 drive follows line after sync latency
    hold(1'b1, 3);
    chk("R9 drive rise", int'(drive_on), 1);
    chk("R9 shutdown cleared", int'(shutdown), 0);

    // R5 pulse inside the init window ignored
    pulse(6, 8);
    expect_lvl("R5 init ignore", 0);
    hold(1'b1, 50);

    // R3 three accepted pulses, R2 value 61
    pulse(6, 8); pulse(6, 8); pulse(6, 8);
    expect_lvl("R3 three steps", 3);

    // R6 glitch
    pulse(2, 8);
    expect_lvl("R6 glitch", 3);

    // R7 gap between max pulse and shutdown; R9 drive low mid-gap
    hold(1'b0, 10);
    chk("R9 drive low", int'(drive_on), 0);
    chk("R7 no shutdown", int'(shutdown), 0);
    hold(1'b0, 20);
    hold(1'b1, 8);
    expect_lvl("R7 gap", 3);

    // R10 short high before a low: second low not counted
    pulse(6, 2);
    hold(1'b0, 6);
    hold(1'b1, 8);
    expect_lvl("R10 short high", 4);

    // R2 dimmest step, R4 wrap
    pulse(6, 8); pulse(6, 8); pulse(6, 8);
    expect_lvl("R2 dimmest", 7);
    pulse(6, 8);
    expect_lvl("R4 wrap", 0);

    // R8 long low
    pulse(6, 8);
    expect_lvl("R3 one step", 1);
    hold(1'b0, 70);
    chk("R8 shutdown", int'(shutdown), 1);
    chk("R8 drive off", int'(drive_on), 0);
    expect_lvl("R8 level reset", 0);

    // R5 after shutdown re-arm needed
    hold(1'b1, 10);
    pulse(6, 8);
    expect_lvl("R5 post-shutdown ignore", 0);
    hold(1'b1, 45);
    pulse(6, 8);
    expect_lvl("R3 after re-arm", 1);

    hold(1'b1, 4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule